// File: doc/BRIEF.md
# Windowed IF Frequency Counter

This block decides whether an intermediate-frequency clock is close enough to its nominal frequency. It does not report the frequency. A time base taken from the crystal clock opens a gate of known length. During the gate, a down-counter in the IF clock domain starts from the count that the nominal frequency would produce and steps down once per IF cycle. When the gate closes, the signed value left in the counter is the residual. The block accepts the input when the residual is small enough.

The crystal domain holds three parts: a 14-bit programmable prescaler that makes the time-base tick, a gate controller that counts a power-of-two number of ticks, and the receiving half of a request/acknowledge handshake. The IF domain holds a two-flop gate synchronizer, the preload and count logic, and the window decision. The decision returns to the crystal domain with a one-cycle valid strobe. The configuration inputs are treated as quasi-static: software changes them with the mode set to off, and they stay unchanged while measurements run.

Top module: `ifc_window_counter`

## Requirements
- R1: When `mode` is 2'b00 (off), no gate opens and `result_valid` stays low. Any decision still in flight when the mode turns off is discarded.
- R2: The prescaler raises one time-base tick every N crystal cycles, where N is `presc_div`. A value of 0 acts as 1. A gate opens only on a tick.
- R3: A gate stays open for exactly 2^`gate_sel` ticks, which is 2^`gate_sel`·N crystal cycles.
- R4: At the first IF cycle of a gate, the counter is loaded with 2^`gate_sel`·P + T and then counts down once per IF cycle while the gate is open. P is the nominal count per tick for the mode (modes 01, 10, 11 use parameters NOM_FM, NOM_AM, NOM_UPC). T is the 4-bit two's-complement value `center_trim[3:0]`, doubled when `center_trim[4]` is 1.
- R5: In mode 2'b10 the counter works modulo 2^11. In modes 2'b01 and 2'b11 it works modulo 2^21. The residual is the counter value read as a signed number of that width.
- R6: `in_window` is 1 exactly when -2^`win_exp` ≤ residual ≤ 2^`win_exp`.
- R7: Each completed measurement produces one `result_valid` pulse, one crystal cycle long. `in_window` changes in the same cycle and holds its value until the next pulse.
- R8: The decision crosses into the crystal domain through a four-phase request/acknowledge handshake. The IF side keeps its request and its result unchanged until it sees the acknowledge. No new gate opens until the handshake has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal reference clock |
| xtal_rst | input | 1 | Synchronous active-high reset, crystal domain |
| if_clk | input | 1 | Conditioned IF input used as a clock |
| if_rst | input | 1 | Synchronous active-high reset, IF domain |
| mode | input | 2 | 00 off, 01 FM, 10 AM, 11 AM up-conversion |
| presc_div | input | 14 | Prescaler divide value N |
| gate_sel | input | 3 | Gate length exponent, in ticks |
| win_exp | input | 3 | Window half-width exponent |
| center_trim | input | 5 | Preload trim: [3:0] signed offset, [4] doubles it |
| result_valid | output | 1 | One-cycle strobe marking a new decision |
| in_window | output | 1 | Latest decision: 1 when the residual is inside the window |

## Verification
The bench sets the IF clock period so that a chosen number of IF cycles falls inside the gate. It then tries an exact match, deviations well above and well below the nominal count, and the same deviation under a wider window; together these separate the sign handling from the window width. Trim values of each sign, including one with the doubling bit set, move the center onto an off-nominal frequency, so a wrong trim decode flips the decision. A deviation of exactly 2048 counts is accepted in AM mode and rejected in FM mode, which separates the 11-bit width from the 21-bit width. Further runs with a divide value of 0, in up-conversion mode, and with the mode turned off check the prescaler corner and the valid suppression.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    localparam int CNT_W  = 21;
    localparam int AM_W   = 11;
    localparam int PRE_W  = 14;
    localparam int SEL_W  = 3;
    localparam int EW_W   = 3;
    localparam int CF_W   = 5;
    localparam int TCNT_W = (1 << SEL_W);

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_FM  = 2'b01,
        MODE_AM  = 2'b10,
        MODE_UPC = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_GATE,
        GS_WAIT_REQ,
        GS_WAIT_DROP
    } gate_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] preload;
        logic             narrow;
        logic [EW_W-1:0]  ew;
    } meas_cfg_t;

    function automatic int nominal_of(mode_e m, int fm, int am, int upc);
        case (m)
            MODE_FM:  return fm;
            MODE_AM:  return am;
            MODE_UPC: return upc;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [CNT_W+1:0] trim_of(logic [CF_W-1:0] cf);
        logic [CNT_W+1:0] t;
        t = {{(CNT_W-2){cf[3]}}, cf[3:0]};
        if (cf[4]) t = t << 1;
        return t;
    endfunction

    function automatic logic [CNT_W-1:0] preload_of(int nom, logic [SEL_W-1:0] sel,
                                                     logic [CF_W-1:0] cf);
        logic [CNT_W+1:0] base;
        logic [CNT_W+1:0] sum;
        base = (CNT_W+2)'(nom) << sel;
        sum  = base + trim_of(cf);
        return sum[CNT_W-1:0];
    endfunction

    function automatic logic signed [CNT_W:0] residual_of(logic [CNT_W-1:0] c, logic narrow);
        if (narrow) return {{(CNT_W+1-AM_W){c[AM_W-1]}}, c[AM_W-1:0]};
        return {c[CNT_W-1], c};
    endfunction

    function automatic logic in_window_of(logic signed [CNT_W:0] r, logic [EW_W-1:0] ew);
        logic signed [CNT_W+1:0] lim;
        logic signed [CNT_W+1:0] rx;
        lim = $signed((CNT_W+2)'(1) << ew);
        rx  = {r[CNT_W], r};
        return (rx <= lim) && (rx >= -lim);
    endfunction

endpackage

// File: rtl/ifc_sync.sv
module ifc_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ifc_prescaler.sv
module ifc_prescaler
    import ifc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] last;

    assign last = (div == '0) ? '0 : div - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R2: two ticks never sit back to back unless the divide is 1 or 0
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && div > 14'd1 && $stable(div)) |=> !tick);
endmodule

// File: rtl/ifc_gate_ctrl.sv
module ifc_gate_ctrl
    import ifc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             req_s,
    input  logic             res_in,
    output logic             gate,
    output logic             ack,
    output logic             valid,
    output logic             in_window
);
    gate_state_e      state;
    logic [TCNT_W-1:0] tcnt;
    logic [TCNT_W-1:0] tlast;

    assign tlast = (TCNT_W'(1) << sel) - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= GS_IDLE;
            tcnt      <= '0;
            gate      <= 1'b0;
            ack       <= 1'b0;
            valid     <= 1'b0;
            in_window <= 1'b0;
        end else if (!en) begin
            state <= GS_IDLE;
            gate  <= 1'b0;
            valid <= 1'b0;
            ack   <= req_s;
        end else begin
            valid <= 1'b0;
            case (state)
                GS_IDLE: begin
                    ack <= req_s;
                    if (tick && !req_s && !ack) begin
                        gate  <= 1'b1;
                        tcnt  <= '0;
                        state <= GS_GATE;
                    end
                end
                GS_GATE: begin
                    if (tick) begin
                        if (tcnt == tlast) begin
                            gate  <= 1'b0;
                            state <= GS_WAIT_REQ;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                GS_WAIT_REQ: begin
                    if (req_s) begin
                        in_window <= res_in;
                        valid     <= 1'b1;
                        ack       <= 1'b1;
                        state     <= GS_WAIT_DROP;
                    end
                end
                default: begin
                    if (!req_s) begin
                        ack   <= 1'b0;
                        state <= GS_IDLE;
                    end
                end
            endcase
        end
    end

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    assert_off_no_valid_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> !valid);
    assert_gate_opens_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> $past(tick));
    assert_gate_closes_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(gate) |-> ($past(tick) || !$past(en)));
    assert_no_gate_during_handshake_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> !$past(ack));
endmodule

// File: rtl/ifc_if_counter.sv
module ifc_if_counter
    import ifc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      gate_s,
    input  meas_cfg_t cfg,
    input  logic      ack_s,
    output logic      req,
    output logic      res
);
    logic             gate_d;
    logic             g_rise;
    logic             g_fall;
    logic [CNT_W-1:0] cnt;

    assign g_rise = gate_s && !gate_d;
    assign g_fall = !gate_s && gate_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_d <= 1'b0;
            cnt    <= '0;
            req    <= 1'b0;
            res    <= 1'b0;
        end else begin
            gate_d <= gate_s;
            if (g_rise)      cnt <= cfg.preload - 1'b1;
            else if (gate_s) cnt <= cnt - 1'b1;
            if (g_fall) begin
                res <= in_window_of(residual_of(cnt, cfg.narrow), cfg.ew);
                req <= 1'b1;
            end else if (ack_s) begin
                req <= 1'b0;
            end
        end
    end

    assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
        (req && !ack_s && !g_fall) |=> req);
    assert_result_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (req && $past(req) && !$past(g_fall)) |-> $stable(res));
    assert_count_steps_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(gate_s) && $past(gate_d) && gate_d) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ifc_window_counter.sv
module ifc_window_counter
    import ifc_pkg::*;
#(
    parameter int NOM_FM  = 1712,
    parameter int NOM_AM  = 450,
    parameter int NOM_UPC = 10700
) (
    input  logic             xtal_clk,
    input  logic             xtal_rst,
    input  logic             if_clk,
    input  logic             if_rst,
    input  logic [1:0]       mode,
    input  logic [PRE_W-1:0] presc_div,
    input  logic [SEL_W-1:0] gate_sel,
    input  logic [EW_W-1:0]  win_exp,
    input  logic [CF_W-1:0]  center_trim,
    output logic             result_valid,
    output logic             in_window
);
    mode_e     mode_q;
    logic      en;
    logic      tick;
    logic      gate;
    logic      gate_s;
    logic      ack;
    logic      ack_s;
    logic      req;
    logic      req_s;
    logic      res;
    meas_cfg_t cfg;

    assign mode_q      = mode_e'(mode);
    assign en          = (mode_q != MODE_OFF);
    assign cfg.preload = preload_of(nominal_of(mode_q, NOM_FM, NOM_AM, NOM_UPC),
                                    gate_sel, center_trim);
    assign cfg.narrow  = (mode_q == MODE_AM);
    assign cfg.ew      = win_exp;

    ifc_prescaler u_presc (
        .clk (xtal_clk), .rst (xtal_rst), .en (en), .div (presc_div), .tick (tick)
    );

    ifc_gate_ctrl u_gate (
        .clk (xtal_clk), .rst (xtal_rst), .en (en), .tick (tick), .sel (gate_sel),
        .req_s (req_s), .res_in (res), .gate (gate), .ack (ack),
        .valid (result_valid), .in_window (in_window)
    );

    ifc_sync u_sync_gate (.clk (if_clk),   .rst (if_rst),   .d (gate), .q (gate_s));
    ifc_sync u_sync_ack  (.clk (if_clk),   .rst (if_rst),   .d (ack),  .q (ack_s));
    ifc_sync u_sync_req  (.clk (xtal_clk), .rst (xtal_rst), .d (req),  .q (req_s));

    ifc_if_counter u_count (
        .clk (if_clk), .rst (if_rst), .gate_s (gate_s), .cfg (cfg),
        .ack_s (ack_s), .req (req), .res (res)
    );
endmodule

// File: tb/ifc_window_counter_bench.sv
`timescale 1ns/1ps
module ifc_window_counter_bench;
    localparam int NFM = 16, NAM = 8, NUPC = 20;

    logic        xtal_clk = 1'b0, if_clk = 1'b0;
    logic        xtal_rst = 1'b1, if_rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic [13:0] presc_div = 14'd4;
    logic [2:0]  gate_sel = 3'd3, win_exp = 3'd2;
    logic [4:0]  center_trim = 5'd0;
    logic        result_valid, in_window;

    realtime if_half = 2.5;
    int vectors = 0, fails = 0, n_valid = 0, cycles = 0;
    bit known = 0, exp_win = 0, prev_v = 0;
    string tag = "R6";

    ifc_window_counter #(.NOM_FM(NFM), .NOM_AM(NAM), .NOM_UPC(NUPC)) u_ifc_window_counter (
        .xtal_clk, .xtal_rst, .if_clk, .if_rst, .mode, .presc_div, .gate_sel,
        .win_exp, .center_trim, .result_valid, .in_window
    );

    always #5 xtal_clk = ~xtal_clk;
    initial forever #(if_half) if_clk = ~if_clk;

    // Reference decision from the requirements (R4, R5, R6)
    function automatic bit model(int m, int sel, int ew, int cf, int n);
        int nom, t, r, w;
        nom = (m == 1) ? NFM : (m == 2) ? NAM : NUPC;
        t = cf & 15; if (t > 7) t -= 16;
        if (cf & 16) t *= 2;
        r = (nom << sel) + t - n;
        w = (m == 2) ? 11 : 21;
        r = r & ((1 << w) - 1);
        if (r >= (1 << (w - 1))) r -= (1 << w);
        return (r <= (1 << ew)) && (r >= -(1 << ew));
    endfunction

    // Per-clock comparison against the model
    always @(negedge xtal_clk) begin
        cycles++;
        if (!xtal_rst) begin
            vectors++;
            if (mode == 2'b00 && result_valid) begin
                fails++; $display("FAIL R1: valid=%0b expected 0 while off", result_valid);
            end
            if (prev_v && result_valid) begin
                fails++; $display("FAIL R7: valid=1 expected 0 after a pulse");
            end
            if (result_valid) begin
                known = 1; n_valid++;
            end
            if (known && in_window !== exp_win) begin
                fails++;
                $display("FAIL %s: in_window=%0b expected %0b", tag, in_window, exp_win);
            end
            prev_v = result_valid;
        end
        if (cycles > 190000) begin
            fails++; $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic run(input int m, input int pd, input int sel, input int ew,
                       input int cf, input int n, input string t);
        int pd_eff, start, waited;
        @(posedge xtal_clk); #1 mode = 2'b00; known = 0;
        repeat (40) @(posedge xtal_clk);
        #1;
        pd_eff = (pd == 0) ? 1 : pd;
        presc_div = 14'(pd); gate_sel = 3'(sel); win_exp = 3'(ew); center_trim = 5'(cf);
        if_half = ((1 << sel) * pd_eff * 10.0) / (2.0 * n);
        exp_win = model(m, sel, ew, cf, n);
        tag = t;
        repeat (4) @(posedge xtal_clk);
        #1 mode = 2'(m);
        start = n_valid; waited = 0;
        while (n_valid < start + 2 && waited < 3000) begin
            @(posedge xtal_clk); waited++;
        end
        if (n_valid < start + 2) begin
            fails++;
            $display("FAIL %s: pulses=%0d expected %0d", t, n_valid - start, 2);
        end
    endtask

    initial begin
        repeat (3) @(posedge xtal_clk);
        #1 xtal_rst = 0; if_rst = 0;
        @(negedge xtal_clk);
        vectors++;
        if (result_valid !== 1'b0 || in_window !== 1'b0) begin
            fails++; $display("FAIL R7: reset outputs %0b%0b expected 00", result_valid, in_window);
        end
        run(2, 4, 3, 2, 0, 64, "R6 exact");                // residual 0
        run(2, 4, 3, 2, 0, 74, "R6 R3 fast");              // residual -10
        run(2, 4, 3, 2, 0, 54, "R6 R2 slow");              // residual +10
        run(2, 4, 3, 4, 0, 74, "R6 wide");                 // -10 inside +-16
        run(2, 4, 3, 2, 5'b00110, 70, "R4 trim+6");        // preload 70
        run(2, 4, 3, 2, 5'b11101, 58, "R4 trim-6");        // -3 doubled
        run(2, 4, 5, 2, 0, 256 + 2048, "R5 am wrap");      // 11-bit wrap -> 0
        run(1, 4, 5, 2, 0, 512 + 2048, "R5 fm 21bit");     // stays -2048
        run(1, 4, 5, 2, 0, 512, "R5 fm exact");
        run(3, 4, 3, 2, 0, 160, "R8 upc");
        run(3, 4, 3, 2, 0, 100, "R8 upc off");
        run(2, 0, 3, 2, 0, 64, "R2 div0");
        // R1: off mode, no pulses over a long stretch
        @(posedge xtal_clk); #1 mode = 2'b00; known = 0;
        begin
            int s; s = n_valid;
            repeat (2000) @(posedge xtal_clk);
            vectors++;
            if (n_valid != s) begin
                fails++; $display("FAIL R1: pulses=%0d expected 0", n_valid - s);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule